// File: doc/BRIEF.md
# Serial ADC Frame Reader

This controller is the master side of a synchronous serial link to a delta-sigma converter that delivers each conversion as a 32-bit word. The word holds two status bits, a sign bit, a 24-bit magnitude field and five sub-LSB bits. One pulse on `start_i` runs one read. The controller first checks whether the converter is ready. It drops chip select with the serial clock held low and waits a settle time. It then samples the data line. A high level means the converter is still busy, so chip select is released for a gap and the check is repeated. If the converter is still busy after a fixed number of checks, the read is abandoned.

Once the data line reads low, the controller runs 32 serial clock periods. It captures the data line on every rising edge. At the same time it shifts a configuration word onto its data output, most significant bit first, and holds that output low once the word is used up. It then releases chip select and checks the status bits. A good frame is unpacked into a saturated signed 24-bit result and the sub-LSB bits, and a one-cycle valid strobe is issued. A bad frame or a timeout gives a one-cycle error strobe instead.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held and after it is released with no start, `cs_n_o` is 1, `sck_o`, `sdi_o`, `valid_o`, `err_o` and `busy_o` are 0, and `result_o` and `sublsb_o` are 0.
- R2: A `start_i` pulse while idle begins a read and raises `busy_o` until the strobe. A `start_i` pulse while a read is in progress has no effect: it adds no extra chip-select cycle and no extra strobe.
- R3: Each readiness check drives `cs_n_o` low with `sck_o` low and samples `sdo_i` SETTLE clocks later. If the sample is high, `cs_n_o` returns high for GAP clocks before the next check. A read with b busy checks (b < MAX_POLLS) therefore shows b+1 falling edges of `cs_n_o`.
- R4: If MAX_POLLS checks in a row read busy, the read ends after exactly MAX_POLLS chip-select falls, with no SCK edge and with one error strobe instead of a valid strobe.
- R5: A read after a ready check produces exactly 32 rising edges of `sck_o`, each high and low phase lasting HALF_DIV clocks. `sck_o` is low whenever `cs_n_o` changes and whenever `cs_n_o` is high.
- R6: On the first CFG_W rising SCK edges, `sdi_o` carries the configuration word latched at start, MSB first. On the remaining edges of the frame `sdi_o` is 0, and it is 0 whenever `cs_n_o` is high.
- R7: Frame bits are numbered 31 (first received) down to 0. If bit 31 or bit 30 is 1, the read ends with an error strobe, no valid strobe, and `result_o`/`sublsb_o` unchanged. The valid and error strobes are never high together.
- R8: On a good frame, `sublsb_o` is bits 4..0. `result_o` is the 25-bit two's-complement value formed by the inverted bit 29 (bit 29 = 1 means positive) placed above the field in bits 28..5, saturated to the signed 24-bit range: 0x7FFFFF when positive with field bit 23 set, 0x800000 when negative with field bit 23 clear, and the field itself otherwise.
- R9: The valid or error strobe lasts one clock. It rises one clock after `cs_n_o` returns high, and `busy_o` drops with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one read |
| cfg_i | input | CFG_W | Configuration word sent on SDI, latched at start |
| busy_o | output | 1 | A read is in progress |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter |
| sdo_i | input | 1 | Serial data and ready flag from the converter |
| result_o | output | 24 | Saturated signed conversion result |
| sublsb_o | output | 5 | Sub-LSB bits of the last good frame |
| valid_o | output | 1 | One-cycle pulse: new good result |
| err_o | output | 1 | One-cycle pulse: bad status bits or poll timeout |

## Verification
The hardest case to reach is a frame whose first bit is 1 even though the readiness check just read 0. The check and bit 31 come from the same line before any clock edge, so a plain busy converter can never produce this case. The bench's converter model drives the line low through the settle window. It then changes the line to the frame's bit 31 during the gap before the first rising SCK edge. Timeout and just-below-timeout reads are produced by a model that answers a chosen number of checks as busy. Random frames, busy counts and configuration words are mixed with saturation and sign corners and with a start pulse issued in the middle of a read.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 24;
  localparam int SUB_W   = 5;
  localparam int BIT_ST1 = 31;
  localparam int BIT_ST0 = 30;
  localparam int BIT_SGN = 29;
  localparam int FLD_LSB = SUB_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_GAP, ST_XFER, ST_TAIL, ST_FIN
  } afr_state_e;

  typedef struct packed {
    logic                     stat_ok;
    logic signed [DATA_W-1:0] value;
    logic [SUB_W-1:0]         sub;
  } afr_word_t;
endpackage

// File: rtl/afr_clkdiv.sv
module afr_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(HALF - 1));

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/afr_shift.sv
module afr_shift #(
  parameter int FRAME_W = 32,
  parameter int CFG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CFG_W-1:0]   cfg,
  input  logic               advance,
  input  logic               capture,
  input  logic               sdo,
  output logic [FRAME_W-1:0] frame,
  output logic               tx_bit
);
  logic [CFG_W-1:0]   tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)         tx_d = cfg;
    else if (advance) tx_d = tx_q << 1;
  end

  always_comb begin
    rx_d = rx_q;
    if (capture) rx_d = {rx_q[FRAME_W-2:0], sdo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign frame  = rx_q;
  assign tx_bit = tx_q[CFG_W-1];

  // R6
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && (advance || capture)));
endmodule

// File: rtl/afr_unpack.sv
module afr_unpack
  import afr_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output afr_word_t          word
);
  logic              pos;
  logic [DATA_W-1:0] field;

  assign pos   = frame[BIT_SGN];
  assign field = frame[FLD_LSB +: DATA_W];

  always_comb begin
    word.stat_ok = !frame[BIT_ST1] && !frame[BIT_ST0];
    word.sub     = frame[SUB_W-1:0];
    if (pos) word.value = field[DATA_W-1] ? {1'b0, {(DATA_W-1){1'b1}}} : field;
    else     word.value = field[DATA_W-1] ? field : {1'b1, {(DATA_W-1){1'b0}}};
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import afr_pkg::*;
#(
  parameter int HALF_DIV  = 3,
  parameter int SETTLE    = 4,
  parameter int GAP       = 3,
  parameter int MAX_POLLS = 6,
  parameter int CFG_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CFG_W-1:0]         cfg_i,
  output logic                     busy_o,
  output logic                     cs_n_o,
  output logic                     sck_o,
  output logic                     sdi_o,
  input  logic                     sdo_i,
  output logic signed [DATA_W-1:0] result_o,
  output logic [SUB_W-1:0]         sublsb_o,
  output logic                     valid_o,
  output logic                     err_o
);
  localparam int HALF_EFF   = (HALF_DIV < 2) ? 2 : HALF_DIV;
  localparam int SETTLE_EFF = (SETTLE < 1) ? 1 : SETTLE;
  localparam int GAP_EFF    = (GAP < 1) ? 1 : GAP;
  localparam int POLLS_EFF  = (MAX_POLLS < 1) ? 1 : MAX_POLLS;
  localparam int TMAX       = (SETTLE_EFF > GAP_EFF) ? SETTLE_EFF : GAP_EFF;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int PW         = $clog2(POLLS_EFF + 1);
  localparam int BW         = $clog2(FRAME_W + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  afr_state_e         state_q, state_d;
  logic [TW-1:0]      tmr_q, tmr_d;
  logic [PW-1:0]      poll_q, poll_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic               cs_n_q, cs_n_d;
  logic               sck_q, sck_d;
  logic               tmo_q, tmo_d;
  logic               valid_q, valid_d;
  logic               err_q, err_d;
  logic signed [DATA_W-1:0] res_q, res_d;
  logic [SUB_W-1:0]   sub_q, sub_d;

  logic               tick, load, adv, cap, tx_bit;
  logic [FRAME_W-1:0] frame;
  afr_word_t          word;

  afr_clkdiv #(.HALF(HALF_EFF)) u_div (
    .clk  (clk),
    .rst_n(rst_s_n),
    .en   (state_q == ST_XFER),
    .tick (tick)
  );

  afr_shift #(.FRAME_W(FRAME_W), .CFG_W(CFG_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load   (load),
    .cfg    (cfg_i),
    .advance(adv),
    .capture(cap),
    .sdo    (sdo_i),
    .frame  (frame),
    .tx_bit (tx_bit)
  );

  afr_unpack u_unpack (
    .frame(frame),
    .word (word)
  );

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    poll_d  = poll_q;
    bit_d   = bit_q;
    cs_n_d  = cs_n_q;
    sck_d   = sck_q;
    tmo_d   = tmo_q;
    res_d   = res_q;
    sub_d   = sub_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    load    = 1'b0;
    adv     = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          cs_n_d  = 1'b0;
          tmr_d   = '0;
          poll_d  = '0;
          tmo_d   = 1'b0;
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (tmr_q == TW'(SETTLE_EFF - 1)) begin
          tmr_d = '0;
          if (!sdo_i) begin
            bit_d   = '0;
            state_d = ST_XFER;
          end else if (poll_q == PW'(POLLS_EFF - 1)) begin
            tmo_d   = 1'b1;
            cs_n_d  = 1'b1;
            state_d = ST_FIN;
          end else begin
            poll_d  = poll_q + PW'(1);
            cs_n_d  = 1'b1;
            state_d = ST_GAP;
          end
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_GAP: begin
        if (tmr_q == TW'(GAP_EFF - 1)) begin
          tmr_d   = '0;
          cs_n_d  = 1'b0;
          state_d = ST_POLL;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            cap   = 1'b1;
            bit_d = bit_q + BW'(1);
          end else begin
            sck_d = 1'b0;
            if (bit_q == BW'(FRAME_W)) state_d = ST_TAIL;
            else                       adv     = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        cs_n_d  = 1'b1;
        state_d = ST_FIN;
      end
      ST_FIN: begin
        if (tmo_q || !word.stat_ok) begin
          err_d = 1'b1;
        end else begin
          valid_d = 1'b1;
          res_d   = word.value;
          sub_d   = word.sub;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      poll_q  <= '0;
      bit_q   <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      tmo_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
      sub_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      poll_q  <= poll_d;
      bit_q   <= bit_d;
      cs_n_q  <= cs_n_d;
      sck_q   <= sck_d;
      tmo_q   <= tmo_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      res_q   <= res_d;
      sub_q   <= sub_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign cs_n_o   = cs_n_q;
  assign sck_o    = sck_q;
  assign sdi_o    = (state_q == ST_XFER) && tx_bit;
  assign result_o = res_q;
  assign sublsb_o = sub_q;
  assign valid_o  = valid_q;
  assign err_o    = err_q;

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n_q |-> !sck_q);
  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_q <= BW'(FRAME_W));
  // R3
  poll_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_POLL || state_q == ST_GAP) |-> !sck_q);
  // R6
  sdi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n_q |-> !sdi_o);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(valid_q && err_q));
  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_q || err_q) |=> !(valid_q || err_q));
  // R9
  strobe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_q || err_q) |-> (cs_n_q && $past(cs_n_q)));
  // R7
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_q |-> $stable(res_q));
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int HALF = 3, SETTLE = 4, GAP = 3, MAXP = 6, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] cfg_i = '0;
  logic busy_o, cs_n_o, sck_o, sdi_o, valid_o, err_o;
  logic sdo_i = 1'b0;
  logic signed [23:0] result_o;
  logic [4:0] sublsb_o;

  always #2 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HALF), .SETTLE(SETTLE), .GAP(GAP),
                     .MAX_POLLS(MAXP), .CFG_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
    .busy_o(busy_o), .cs_n_o(cs_n_o), .sck_o(sck_o), .sdi_o(sdi_o),
    .sdo_i(sdo_i), .result_o(result_o), .sublsb_o(sublsb_o),
    .valid_o(valid_o), .err_o(err_o));

  int checks = 0, errors = 0;

  // converter model
  logic [31:0] s_frame = '0;
  int          s_busy = 0;
  int          s_idx = 31;
  logic [31:0] sdi_cap = '0;

  always @(negedge cs_n_o) begin
    if (rst_n) begin
      #1;
      if (s_busy > 0) begin
        sdo_i = 1'b1;
        s_busy--;
      end else begin
        sdo_i = 1'b0;
        s_idx = 31;
        repeat (SETTLE + 1) @(posedge clk);
        #1 sdo_i = s_frame[31];
      end
    end
  end
  always @(negedge sck_o) if (!cs_n_o) begin
    #1;
    s_idx--;
    sdo_i = (s_idx >= 0) ? s_frame[s_idx] : 1'b0;
  end
  always @(posedge sck_o) if (!cs_n_o) sdi_cap = {sdi_cap[30:0], sdi_o};

  // port monitor
  int m_falls, m_rises, m_sckbad, m_halfbad, m_v, m_e, m_wide, m_sbad, m_since, m_sdibad;
  logic p_cs = 1'b1, p_sck = 1'b0, p_st = 1'b0;
  bit first_rise;
  always @(negedge clk) begin
    if (rst_n) begin
      m_since++;
      if (p_cs && !cs_n_o) begin m_falls++; if (sck_o) m_sckbad++; first_rise = 1; end
      if (!p_cs && cs_n_o && sck_o) m_sckbad++;
      if (cs_n_o && sck_o) m_sckbad++;
      if (cs_n_o && sdi_o) m_sdibad++;
      if (!p_sck && sck_o) begin
        m_rises++;
        if (!first_rise && m_since != HALF) m_halfbad++;
        first_rise = 0; m_since = 0;
      end
      if (p_sck && !sck_o) begin
        if (m_since != HALF) m_halfbad++;
        m_since = 0;
      end
      if (valid_o) m_v++;
      if (err_o) m_e++;
      if ((valid_o || err_o) && p_st) m_wide++;
      if ((valid_o || err_o) && (!cs_n_o || !p_cs || busy_o)) m_sbad++;
      p_cs = cs_n_o; p_sck = sck_o; p_st = valid_o || err_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_value(input logic [31:0] f);
    logic [23:0] fld = f[28:5];
    if (f[29]) return fld[23] ? 24'h7FFFFF : fld;
    else       return fld[23] ? fld : 24'h800000;
  endfunction

  logic [23:0] mdl_res = '0;
  logic [4:0]  mdl_sub = '0;

  task automatic do_read(input logic [31:0] f, input int busy, input logic [CW-1:0] cfg, input bit extra);
    bit tmo = (busy >= MAXP);
    bit bad = tmo || f[31] || f[30];
    int waitc = 0;
    s_frame = f; s_busy = busy; sdi_cap = '0;
    m_falls = 0; m_rises = 0; m_sckbad = 0; m_halfbad = 0; m_v = 0; m_e = 0;
    m_wide = 0; m_sbad = 0; m_sdibad = 0;
    @(negedge clk); start_i = 1'b1; cfg_i = cfg;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    if (extra) begin
      repeat (25) @(negedge clk);
      start_i = 1'b1; cfg_i = ~cfg;
      @(negedge clk); start_i = 1'b0;
    end
    while (m_v + m_e == 0 && waitc < 5000) begin @(negedge clk); waitc++; end
    repeat (40) @(negedge clk);
    chk(m_falls == (tmo ? MAXP : busy + 1), tmo ? "R4 cs falls" : "R3 cs falls", m_falls, tmo ? MAXP : busy + 1);
    chk(m_rises == (tmo ? 0 : 32), tmo ? "R4 sck rises" : "R5 sck rises", m_rises, tmo ? 0 : 32);
    chk(m_sckbad == 0 && m_halfbad == 0, "R5 sck shape", m_sckbad + m_halfbad, 0);
    if (!tmo) chk(sdi_cap == {cfg, 24'h0}, "R6 sdi bits", sdi_cap, {cfg, 24'h0});
    chk(m_sdibad == 0, "R6 sdi idle", m_sdibad, 0);
    chk(m_v == (bad ? 0 : 1), "R7 valid count", m_v, bad ? 0 : 1);
    chk(m_e == (bad ? 1 : 0), tmo ? "R4 err count" : "R7 err count", m_e, bad ? 1 : 0);
    chk(m_wide == 0 && m_sbad == 0, "R9 strobe timing", m_wide + m_sbad, 0);
    chk(busy_o == 1'b0, "R2 idle after strobe", busy_o, 0);
    if (!bad) begin mdl_res = exp_value(f); mdl_sub = f[4:0]; end
    chk(result_o == mdl_res, bad ? "R7 result held" : "R8 result", result_o, mdl_res);
    chk(sublsb_o == mdl_sub, bad ? "R7 sub held" : "R8 sublsb", sublsb_o, mdl_sub);
  endtask

  function automatic logic [31:0] mkf(input bit s1, input bit s0, input bit sg, input logic [23:0] fld, input logic [4:0] sb);
    return {s1, s0, sg, fld, sb};
  endfunction

  task automatic run_all();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n_o && !sck_o && !sdi_o && !valid_o && !err_o && !busy_o, "R1 reset outputs",
        {cs_n_o, sck_o, sdi_o, valid_o, err_o, busy_o}, 6'b100000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(cs_n_o && !sck_o && !busy_o && result_o == 0 && sublsb_o == 0, "R1 after release",
        {cs_n_o, busy_o, result_o}, {1'b1, 1'b0, 24'h0});
    do_read(mkf(0, 0, 1, 24'h001234, 5'h15), 0, 8'hA5, 0);          // R8 small positive
    do_read(mkf(0, 0, 0, 24'hFFF000, 5'h0A), 2, 8'h3C, 0);          // R8 negative, R3 polls
    do_read(mkf(0, 0, 1, 24'h900000, 5'h1F), 1, 8'hFF, 0);          // R8 clamp high
    do_read(mkf(0, 0, 0, 24'h000000, 5'h01), 0, 8'h01, 0);          // R8 clamp low
    do_read(mkf(0, 0, 1, 24'h7FFFFF, 5'h00), 0, 8'h80, 0);          // R8 max unclamped
    do_read(mkf(0, 1, 1, 24'h111111, 5'h02), 0, 8'h55, 0);          // R7 bit 30
    do_read(mkf(1, 0, 0, 24'h222222, 5'h03), 1, 8'hAA, 0);          // R7 bit 31
    do_read(mkf(0, 0, 1, 24'h333333, 5'h04), MAXP, 8'h0F, 0);       // R4 timeout
    do_read(mkf(0, 0, 0, 24'hC00000, 5'h05), MAXP - 1, 8'hF0, 0);   // R3 last poll ready
    do_read(mkf(0, 0, 1, 24'h0000FF, 5'h06), 1, 8'h69, 1);          // R2 start ignored
    for (int i = 0; i < 24; i++) begin
      logic [31:0] f = $urandom;
      int b = $urandom % 4;
      f[31:30] = 2'b00;
      if ($urandom % 8 == 0) f[31:30] = 2'b01 << ($urandom % 2);
      do_read(f, b, CW'($urandom), ($urandom % 6) == 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule